// File: doc/BRIEF.md
# Privileged/User Address Region Decoder

This block sits beside a processor load/store pipeline and classifies each 32-bit virtual address while address translation is off. It looks at the address, the access direction and the current privilege mode. For each access it reports five things: which region the address falls in, whether the access may be cached, and which write policy a cacheable store uses. It also gives the external physical address, and tells whether the request goes to on-chip I/O, to the store-queue window, to a reserved external area, or raises an address error.

In privileged mode the top three address bits pick one of five regions. The lower half of the space is one cacheable region. Above it sit a cacheable region, an uncached mirror, a second cacheable region and an on-chip I/O region. In user mode only the lower half is reachable, plus a 64 MB store-queue window at 0xE000_0000. Every other user address is an error. Every mirrored region maps onto a 29-bit external space by dropping the top three bits. That external space is cut into eight 64 MB areas chosen by physical bits [28:26], and area 7 is reserved wherever it appears. All results come out after one register stage.

Top module: `addr_region_classifier`

## Requirements
- R1: `outValid` equals `inValid` from one cycle earlier. While `outValid` is low, every flag, select, the region code and the physical address read zero.
- R2: In privileged mode (`inUser`=0), the region code follows address bits [31:29]. 0xx gives P0 (code 0), 100 gives P1 (code 1), 101 gives P2 (code 2), 110 gives P3 (code 3) and 111 gives P4 (code 4).
- R3: `outCacheable` is 1 for P0, P1, P3 and U0, and 0 for P2, P4, the store-queue window and address errors.
- R4: `outWriteThru` (1 = write-through, 0 = copy-back) is 0 for reads and for non-cacheable accesses. For cacheable writes in P0, P3 or U0 it equals `ctlWriteThru`. For cacheable writes in P1 it equals the inverse of `ctlCopyBack`.
- R5: For P0, P1, P2, P3 and U0, `outPhysAddr` equals input address bits [28:0]. For every other outcome it is zero.
- R6: `outReserved` is 1 exactly when the access maps to external memory and physical bits [28:26] are 111. This covers physical 0x1C00_0000 to 0x1FFF_FFFF in any mirrored region.
- R7: A P4 access sets `outIoSel`. It gives no physical address and no reserved flag.
- R8: In user mode, addresses 0x0000_0000 to 0x7FFF_FFFF decode as U0 (code 5).
- R9: In user mode, addresses 0xE000_0000 to 0xE3FF_FFFF set `outSqSel` with region code 6. These accesses are not cacheable and give no physical address.
- R10: In user mode, 0x8000_0000 to 0xDFFF_FFFF and 0xE400_0000 to 0xFFFF_FFFF set `outAddrErr` with region code 7. Every other select and flag reads zero, and so does the physical address.
- R11: The store-queue window exists only in user mode. A privileged access to 0xE000_0000 decodes as P4 with `outIoSel` set and `outSqSel` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Access request strobe |
| inAddr | input | 32 | Virtual address |
| inWrite | input | 1 | 1 = store, 0 = load |
| inUser | input | 1 | 1 = user mode, 0 = privileged |
| ctlWriteThru | input | 1 | Write-through select for P0, P3, U0 |
| ctlCopyBack | input | 1 | Copy-back select for P1 |
| outValid | output | 1 | Registered result valid |
| outRegion | output | 3 | Region code (0..7 as in R2, R8–R10) |
| outCacheable | output | 1 | Access may use the cache |
| outWriteThru | output | 1 | Write policy for cacheable stores |
| outPhysAddr | output | 29 | External physical address |
| outIoSel | output | 1 | On-chip I/O select |
| outSqSel | output | 1 | Store-queue select |
| outReserved | output | 1 | Reserved external area hit |
| outAddrErr | output | 1 | User-mode address error |

## Verification
The checker watches several rules on every cycle. The result valid must track the request one cycle later, and an invalid result must be all zero. I/O select, store-queue select and address error must be mutually exclusive. An error must carry no address and no caching, and the write policy must stay silent on loads. A reserved hit must sit in area 7, and the policy must come from the right control bit for P0 and P1. The bench's scenarios are what show the exact region boundaries: the last address of P0 and of P1, both edges of the store-queue window, and the top of the user error range. They also show the reserved alias reappearing in P3 and U0, and the same address decoding differently when only the mode bit changes.

// File: rtl/regionDecodePkg.sv
package regionDecodePkg;

  localparam int TOP_W  = 3;  // address bits stripped to form the physical address
  localparam int AREA_W = 3;  // physical bits naming the external area

  typedef enum logic [2:0] {
    RGN_P0  = 3'd0,
    RGN_P1  = 3'd1,
    RGN_P2  = 3'd2,
    RGN_P3  = 3'd3,
    RGN_P4  = 3'd4,
    RGN_U0  = 3'd5,
    RGN_SQ  = 3'd6,
    RGN_ERR = 3'd7
  } regionCode_t;

  // Strobes from the classifier to the datapath
  typedef struct packed {
    regionCode_t region;
    logic        external;     // address maps to external memory
    logic        cacheable;
    logic        policyFromCb; // write policy taken from copy-back control
    logic        ioSel;
    logic        sqSel;
    logic        addrErr;
  } decodeStrobes_t;

endpackage

// File: rtl/regionDecodeCtrl.sv
module regionDecodeCtrl
  import regionDecodePkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SQ_LOW_W = 26
) (
  input  logic [ADDR_W-SQ_LOW_W-1:0] addrHigh,
  input  logic                       user,
  output decodeStrobes_t             strobes
);
  localparam int SQ_TAG_W = ADDR_W - SQ_LOW_W;
  localparam logic [SQ_TAG_W-1:0] SQ_TAG = {{TOP_W{1'b1}}, {(SQ_TAG_W-TOP_W){1'b0}}};

  logic [TOP_W-1:0] topBits;
  assign topBits = addrHigh[SQ_TAG_W-1 -: TOP_W];

  always_comb begin
    strobes = '0;
    if (!user) begin
      unique casez (topBits)
        3'b0??: begin strobes.region = RGN_P0; strobes.external = 1'b1; strobes.cacheable = 1'b1; end
        3'b100: begin
          strobes.region       = RGN_P1;
          strobes.external     = 1'b1;
          strobes.cacheable    = 1'b1;
          strobes.policyFromCb = 1'b1;
        end
        3'b101: begin strobes.region = RGN_P2; strobes.external = 1'b1; end
        3'b110: begin strobes.region = RGN_P3; strobes.external = 1'b1; strobes.cacheable = 1'b1; end
        default: begin strobes.region = RGN_P4; strobes.ioSel = 1'b1; end
      endcase
    end else if (!topBits[TOP_W-1]) begin
      strobes.region    = RGN_U0;
      strobes.external  = 1'b1;
      strobes.cacheable = 1'b1;
    end else if (addrHigh == SQ_TAG) begin
      strobes.region = RGN_SQ;
      strobes.sqSel  = 1'b1;
    end else begin
      strobes.region  = RGN_ERR;
      strobes.addrErr = 1'b1;
    end
  end

endmodule

// File: rtl/regionDecodeDatapath.sv
module regionDecodeDatapath
  import regionDecodePkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int PHYS_W = ADDR_W - TOP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [PHYS_W-1:0] physIn,
  input  logic              write,
  input  logic              wtBit,
  input  logic              cbBit,
  input  decodeStrobes_t    strobes,
  output logic              validQ,
  output regionCode_t       regionQ,
  output logic              cacheableQ,
  output logic              writeThruQ,
  output logic [PHYS_W-1:0] physQ,
  output logic              ioSelQ,
  output logic              sqSelQ,
  output logic              reservedQ,
  output logic              addrErrQ
);
  logic [PHYS_W-1:0] physNext;
  logic              reservedNext;
  logic              policyNext;

  always_comb begin
    physNext     = (valid && strobes.external) ? physIn : '0;
    reservedNext = valid && strobes.external && (physIn[PHYS_W-1 -: AREA_W] == '1);
    policyNext   = 1'b0;
    if (valid && write && strobes.cacheable)
      policyNext = strobes.policyFromCb ? ~cbBit : wtBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ     <= 1'b0;
      regionQ    <= RGN_P0;
      cacheableQ <= 1'b0;
      writeThruQ <= 1'b0;
      physQ      <= '0;
      ioSelQ     <= 1'b0;
      sqSelQ     <= 1'b0;
      reservedQ  <= 1'b0;
      addrErrQ   <= 1'b0;
    end else begin
      validQ     <= valid;
      regionQ    <= valid ? strobes.region : RGN_P0;
      cacheableQ <= valid && strobes.cacheable;
      writeThruQ <= policyNext;
      physQ      <= physNext;
      ioSelQ     <= valid && strobes.ioSel;
      sqSelQ     <= valid && strobes.sqSel;
      reservedQ  <= reservedNext;
      addrErrQ   <= valid && strobes.addrErr;
    end
  end

endmodule

// File: rtl/addr_region_classifier.sv
module addr_region_classifier
  import regionDecodePkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SQ_LOW_W = 26,
  localparam int PHYS_W  = ADDR_W - TOP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  input  logic              inUser,
  input  logic              ctlWriteThru,
  input  logic              ctlCopyBack,
  output logic              outValid,
  output logic [2:0]        outRegion,
  output logic              outCacheable,
  output logic              outWriteThru,
  output logic [PHYS_W-1:0] outPhysAddr,
  output logic              outIoSel,
  output logic              outSqSel,
  output logic              outReserved,
  output logic              outAddrErr
);
  decodeStrobes_t strobes;
  regionCode_t    regionQ;

  regionDecodeCtrl #(.ADDR_W(ADDR_W), .SQ_LOW_W(SQ_LOW_W)) u_ctrl (
    .addrHigh (inAddr[ADDR_W-1:SQ_LOW_W]),
    .user     (inUser),
    .strobes  (strobes)
  );

  regionDecodeDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .valid      (inValid),
    .physIn     (inAddr[PHYS_W-1:0]),
    .write      (inWrite),
    .wtBit      (ctlWriteThru),
    .cbBit      (ctlCopyBack),
    .strobes    (strobes),
    .validQ     (outValid),
    .regionQ    (regionQ),
    .cacheableQ (outCacheable),
    .writeThruQ (outWriteThru),
    .physQ      (outPhysAddr),
    .ioSelQ     (outIoSel),
    .sqSelQ     (outSqSel),
    .reservedQ  (outReserved),
    .addrErrQ   (outAddrErr)
  );

  assign outRegion = regionQ;

endmodule

// File: rtl/regionDecodeChecker.sv
module regionDecodeChecker #(
  parameter int ADDR_W = 32,
  localparam int PHYS_W = ADDR_W - 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] inAddr,
  input logic              inWrite,
  input logic              inUser,
  input logic              ctlWriteThru,
  input logic              ctlCopyBack,
  input logic              outValid,
  input logic [2:0]        outRegion,
  input logic              outCacheable,
  input logic              outWriteThru,
  input logic [PHYS_W-1:0] outPhysAddr,
  input logic              outIoSel,
  input logic              outSqSel,
  input logic              outReserved,
  input logic              outAddrErr
);
  logic [2:0] topIn;
  logic       userSq;
  assign topIn  = inAddr[ADDR_W-1 -: 3];
  assign userSq = (inAddr[ADDR_W-1 -: 6] == 6'b111000);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outRegion == 3'd0 && !outCacheable && !outWriteThru && outPhysAddr == '0
                   && !outIoSel && !outSqSel && !outReserved && !outAddrErr));
  // R10
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outIoSel, outSqSel, outAddrErr}));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    outAddrErr |-> (!outCacheable && !outWriteThru && outPhysAddr == '0 && !outReserved
                    && outRegion == 3'd7));
  // R10
  user_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inUser && topIn[2] && !userSq) |=> outAddrErr);
  // R4
  read_policy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inWrite) |=> !outWriteThru);
  // R4
  p0_policy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWrite && !inUser && !topIn[2]) |=> (outWriteThru == $past(ctlWriteThru)));
  // R4
  p1_policy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWrite && !inUser && topIn == 3'b100) |=> (outWriteThru == !$past(ctlCopyBack)));
  // R4
  policy_cache_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWriteThru |-> outCacheable);
  // R6
  reserved_area_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReserved |-> (outPhysAddr[PHYS_W-1 -: 3] == 3'b111));
  // R7
  io_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    outIoSel |-> (outRegion == 3'd4 && outPhysAddr == '0 && !outCacheable));

endmodule

bind addr_region_classifier regionDecodeChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr), .inWrite(inWrite),
  .inUser(inUser), .ctlWriteThru(ctlWriteThru), .ctlCopyBack(ctlCopyBack),
  .outValid(outValid), .outRegion(outRegion), .outCacheable(outCacheable),
  .outWriteThru(outWriteThru), .outPhysAddr(outPhysAddr), .outIoSel(outIoSel),
  .outSqSel(outSqSel), .outReserved(outReserved), .outAddrErr(outAddrErr)
);

// File: tb/addr_region_classifier_bench.sv
`timescale 1ns/1ps
module addr_region_classifier_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic        inWrite = 1'b0;
  logic        inUser = 1'b0;
  logic        ctlWriteThru = 1'b0;
  logic        ctlCopyBack = 1'b0;
  logic        outValid;
  logic [2:0]  outRegion;
  logic        outCacheable;
  logic        outWriteThru;
  logic [28:0] outPhysAddr;
  logic        outIoSel;
  logic        outSqSel;
  logic        outReserved;
  logic        outAddrErr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  addr_region_classifier u_addr_region_classifier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr), .inWrite(inWrite),
    .inUser(inUser), .ctlWriteThru(ctlWriteThru), .ctlCopyBack(ctlCopyBack),
    .outValid(outValid), .outRegion(outRegion), .outCacheable(outCacheable),
    .outWriteThru(outWriteThru), .outPhysAddr(outPhysAddr), .outIoSel(outIoSel),
    .outSqSel(outSqSel), .outReserved(outReserved), .outAddrErr(outAddrErr)
  );

  // {valid, region, cacheable, writeThru, phys, io, sq, reserved, err}
  function automatic logic [39:0] pack(logic v, logic [2:0] r, logic c, logic w,
                                       logic [28:0] p, logic io, logic sq, logic rs, logic e);
    return {v, r, c, w, p, io, sq, rs, e};
  endfunction

  task automatic expectOut(string req, logic [2:0] r, logic c, logic w, logic [28:0] p,
                           logic io, logic sq, logic rs, logic e);
    logic [39:0] act, exp;
    act = pack(outValid, outRegion, outCacheable, outWriteThru, outPhysAddr,
               outIoSel, outSqSel, outReserved, outAddrErr);
    exp = pack(1'b1, r, c, w, p, io, sq, rs, e);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic wr, logic usr, logic wt, logic cb);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inWrite = wr; inUser = usr;
    ctlWriteThru = wt; ctlCopyBack = cb;
    @(negedge clk);
  endtask

  task automatic testReset();
    checks++;
    if (pack(outValid, outRegion, outCacheable, outWriteThru, outPhysAddr,
             outIoSel, outSqSel, outReserved, outAddrErr) !== '0) begin
      failures++;
      $display("FAIL R1 reset actual=%b expected=0", outValid);
    end
  endtask

  task automatic testPrivRegions();
    drive(32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0);
    expectOut("R2 P0 read", 3'd0, 1, 0, 29'h1234_5678, 0, 0, 0, 0);
    drive(32'h9FFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0);
    expectOut("R2 R6 P1 top", 3'd1, 1, 0, 29'h1FFF_FFF0, 0, 0, 1, 0);
    drive(32'hA000_0040, 1'b1, 1'b0, 1'b1, 1'b0);
    expectOut("R3 R5 P2 write", 3'd2, 0, 0, 29'h0000_0040, 0, 0, 0, 0);
    drive(32'hDC00_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    expectOut("R6 P3 area7", 3'd3, 1, 0, 29'h1C00_0000, 0, 0, 1, 0);
    drive(32'hDBFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0);
    expectOut("R6 P3 area6", 3'd3, 1, 0, 29'h1BFF_FFFC, 0, 0, 0, 0);
    drive(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    expectOut("R2 R6 P0 last", 3'd0, 1, 0, 29'h1FFF_FFFF, 0, 0, 1, 0);
    drive(32'hF000_1234, 1'b1, 1'b0, 1'b1, 1'b1);
    expectOut("R7 P4 io", 3'd4, 0, 0, 29'h0, 1, 0, 0, 0);
  endtask

  task automatic testPolicy();
    drive(32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b0);
    expectOut("R4 P0 wt=1", 3'd0, 1, 1, 29'h0000_1000, 0, 0, 0, 0);
    drive(32'hC000_1000, 1'b1, 1'b0, 1'b0, 1'b0);
    expectOut("R4 P3 wt=0", 3'd3, 1, 0, 29'h0000_1000, 0, 0, 0, 0);
    drive(32'h8000_2000, 1'b1, 1'b0, 1'b0, 1'b1);
    expectOut("R4 P1 cb=1", 3'd1, 1, 0, 29'h0000_2000, 0, 0, 0, 0);
    drive(32'h8000_2000, 1'b1, 1'b0, 1'b1, 1'b0);
    expectOut("R4 P1 cb=0", 3'd1, 1, 1, 29'h0000_2000, 0, 0, 0, 0);
    drive(32'h8000_2000, 1'b0, 1'b0, 1'b1, 1'b0);
    expectOut("R4 P1 read", 3'd1, 1, 0, 29'h0000_2000, 0, 0, 0, 0);
  endtask

  task automatic testUser();
    drive(32'h0000_0100, 1'b1, 1'b1, 1'b1, 1'b0);
    expectOut("R8 R4 U0 write", 3'd5, 1, 1, 29'h0000_0100, 0, 0, 0, 0);
    drive(32'h7C00_0010, 1'b0, 1'b1, 1'b0, 1'b0);
    expectOut("R8 R6 U0 area7", 3'd5, 1, 0, 29'h1C00_0010, 0, 0, 1, 0);
    drive(32'hE000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
    expectOut("R9 sq low", 3'd6, 0, 0, 29'h0, 0, 1, 0, 0);
    drive(32'hE3FF_FFFC, 1'b1, 1'b1, 1'b1, 1'b0);
    expectOut("R9 sq high", 3'd6, 0, 0, 29'h0, 0, 1, 0, 0);
    drive(32'hE400_0000, 1'b1, 1'b1, 1'b1, 1'b0);
    expectOut("R10 above sq", 3'd7, 0, 0, 29'h0, 0, 0, 0, 1);
    drive(32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    expectOut("R10 user P1", 3'd7, 0, 0, 29'h0, 0, 0, 0, 0 | 1'b1);
    drive(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    expectOut("R10 user top", 3'd7, 0, 0, 29'h0, 0, 0, 0, 1);
    drive(32'hDC00_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    expectOut("R10 user P3 area7", 3'd7, 0, 0, 29'h0, 0, 0, 0, 1);
  endtask

  task automatic testModeSwap();
    drive(32'hE000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    expectOut("R11 priv sq addr", 3'd4, 0, 0, 29'h0, 1, 0, 0, 0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    inValid = 1'b0; inAddr = 32'hDC00_0000; inWrite = 1'b1; inUser = 1'b0; ctlWriteThru = 1'b1;
    @(negedge clk);
    checks++;
    if (pack(outValid, outRegion, outCacheable, outWriteThru, outPhysAddr,
             outIoSel, outSqSel, outReserved, outAddrErr) !== '0) begin
      failures++;
      $display("FAIL R1 idle actual=%b%h expected=0", outValid, outPhysAddr);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPrivRegions();
    testPolicy();
    testUser();
    testModeSwap();
    testIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule